// File: doc/BRIEF.md
# YPbPr 4:4:4 to 4:2:2 Output Formatter

This block sits on the pixel-clocked video output path. Each clock it takes one pixel made of three samples, luma (Y) and two colour differences (Pb, Pr), and sends it to three physical output channels named red, green and blue. Under a mode select the pixel goes out unchanged on all three channels (4:4:4). In the other mode it is packed onto two channels (4:2:2), so only 16 of the 24 data lines carry data.

In 4:2:2 mode, green always carries luma. One of red or blue carries chroma, which alternates Pb and Pr on consecutive pixels, and the remaining channel is switched off. Each channel has an output-enable flag that stands in for a high-impedance pin. A routing select picks which of red or blue carries the chroma. Chroma is taken as is: in each pixel only the colour-difference sample that matches the phase is kept and the other is dropped. A mode or routing change waits for the next line start, so no line holds two formats.

Top module: `ypbpr_422_fmt`

## Requirements
- R1: While reset is asserted, every output data channel is zero and all three output-enable flags are low.
- R2: In 4:4:4 mode, each output is registered with one clock of latency: red carries Pr, green carries Y and blue carries Pb, and all three enables are high.
- R3: In 4:2:2 mode, green carries Y one clock later with its enable high.
- R4: In 4:2:2 mode with the routing select at 0, red carries chroma with its enable high and blue has its enable low.
- R5: In 4:2:2 mode with the routing select at 1, blue carries chroma with its enable high and red has its enable low.
- R6: The chroma phase is 0 on a pixel that has line_start high and inverts on every following pixel. Phase 0 forwards Pb and phase 1 forwards Pr. The sample that is not selected is dropped.
- R7: The mode and routing selects are sampled only on a pixel with line_start high, and that setting applies from that pixel onward. Changes made on other pixels have no effect until the next line start.
- R8: A channel with its enable low outputs all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | High on the first pixel of a line |
| mode_422_req | input | 1 | Requested mode: 0 = 4:4:4, 1 = 4:2:2 |
| chroma_on_blue_req | input | 1 | Requested routing: 0 = chroma on red, 1 = chroma on blue |
| in_y | input | CW | Luma sample |
| in_pb | input | CW | Blue colour-difference sample |
| in_pr | input | CW | Red colour-difference sample |
| out_red | output | CW | Red output channel |
| out_green | output | CW | Green output channel |
| out_blue | output | CW | Blue output channel |
| oe_red | output | 1 | Red output enable (low = high impedance) |
| oe_green | output | 1 | Green output enable |
| oe_blue | output | 1 | Blue output enable |

## Verification
A wrong phase bit makes the chroma channel show Pr where Pb is expected. This appears on the first output after a line start, or on the pixel straight after the bit goes wrong. A stale or early copy of the settings turns on, or leaves on, the wrong enable pair, or brings the format change one pixel early within a line. Either is visible at the ports one clock after the pixel concerned. The sweep covers every mode and routing pair over lines of odd and even length, and changes the requests in the middle of lines, so each of these faults reaches an output within one line.

// File: rtl/ypbpr_422_fmt.sv
module ypbpr_422_fmt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          mode_422_req,
  input  logic          chroma_on_blue_req,
  input  logic [CW-1:0] in_y,
  input  logic [CW-1:0] in_pb,
  input  logic [CW-1:0] in_pr,
  output logic [CW-1:0] out_red,
  output logic [CW-1:0] out_green,
  output logic [CW-1:0] out_blue,
  output logic          oe_red,
  output logic          oe_green,
  output logic          oe_blue
);
  logic       mode_act, swap_act, phase_q;
  logic [1:0] live;

  wire          mode_now  = line_start ? mode_422_req       : mode_act;
  wire          swap_now  = line_start ? chroma_on_blue_req : swap_act;
  wire          phase_now = line_start ? 1'b0               : phase_q;
  wire [CW-1:0] chroma    = phase_now ? in_pr : in_pb;
  wire          red_is_c  = mode_now & ~swap_now;
  wire          blue_is_c = mode_now &  swap_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_act  <= 1'b0;
      swap_act  <= 1'b0;
      phase_q   <= 1'b0;
      live      <= 2'd0;
      out_red   <= '0;
      out_green <= '0;
      out_blue  <= '0;
      oe_red    <= 1'b0;
      oe_green  <= 1'b0;
      oe_blue   <= 1'b0;
    end else begin
      mode_act  <= mode_now;
      swap_act  <= swap_now;
      phase_q   <= ~phase_now;
      live      <= (live == 2'd2) ? 2'd2 : live + 2'd1;
      out_green <= in_y;
      oe_green  <= 1'b1;
      out_red   <= !mode_now ? in_pr : (red_is_c  ? chroma : '0);
      out_blue  <= !mode_now ? in_pb : (blue_is_c ? chroma : '0);
      oe_red    <= ~blue_is_c;
      oe_blue   <= ~red_is_c;
    end
  end

  // R3
  green_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live != 2'd0) |-> oe_green);

  // R8
  red_dark_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live != 2'd0 && !oe_red) |-> (out_red == '0));

  // R8
  blue_dark_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live != 2'd0 && !oe_blue) |-> (out_blue == '0));

  // R5
  one_dark_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live != 2'd0) |-> (oe_red || oe_blue));

  // R7
  fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live == 2'd2 && !$past(line_start)) |-> $stable({oe_red, oe_blue}));
endmodule

// File: tb/ypbpr_422_fmt_tb.sv
module ypbpr_422_fmt_tb;
  localparam int CW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0, mode_422_req = 1'b0, chroma_on_blue_req = 1'b0;
  logic [CW-1:0] in_y = '0, in_pb = '0, in_pr = '0;
  logic [CW-1:0] out_red, out_green, out_blue;
  logic oe_red, oe_green, oe_blue;
  int checks = 0, failures = 0;
  bit m_mode = 0, m_swap = 0, m_ph = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ypbpr_422_fmt #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .mode_422_req(mode_422_req), .chroma_on_blue_req(chroma_on_blue_req),
    .in_y(in_y), .in_pb(in_pb), .in_pr(in_pr),
    .out_red(out_red), .out_green(out_green), .out_blue(out_blue),
    .oe_red(oe_red), .oe_green(oe_green), .oe_blue(oe_blue));

  task automatic chk(string tag, logic [CW:0] act, logic [CW:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pix(bit ls, bit mreq, bit sreq, logic [CW-1:0] y, pb, pr);
    logic [CW-1:0] c;
    line_start = ls; mode_422_req = mreq; chroma_on_blue_req = sreq;
    in_y = y; in_pb = pb; in_pr = pr;
    if (ls) begin m_mode = mreq; m_swap = sreq; m_ph = 0; end
    c = m_ph ? pr : pb;
    @(posedge clk); #1;
    if (!m_mode) begin
      chk("R2 red",   {oe_red, out_red},     {1'b1, pr});
      chk("R2 green", {oe_green, out_green}, {1'b1, y});
      chk("R2 blue",  {oe_blue, out_blue},   {1'b1, pb});
    end else begin
      chk("R3 green", {oe_green, out_green}, {1'b1, y});
      if (!m_swap) begin
        chk("R4 R6 red chroma", {oe_red, out_red}, {1'b1, c});
        chk("R8 blue off", {oe_blue, out_blue}, {1'b0, {CW{1'b0}}});
      end else begin
        chk("R5 R6 blue chroma", {oe_blue, out_blue}, {1'b1, c});
        chk("R8 red off", {oe_red, out_red}, {1'b0, {CW{1'b0}}});
      end
    end
    m_ph = ~m_ph;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 red",   {oe_red, out_red},     '0);
    chk("R1 green", {oe_green, out_green}, '0);
    chk("R1 blue",  {oe_blue, out_blue},   '0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int cfg = 0; cfg < 4; cfg++)
      for (int len = 3; len <= 6; len++)
        for (int k = 0; k < len; k++)
          pix(k == 0, cfg[1], cfg[0],
              CW'(cfg * 61 + len * 17 + k * 5 + 1),
              CW'(cfg * 29 + len * 7 + k * 11 + 40),
              CW'(cfg * 13 + len * 3 + k * 23 + 130));
    // R7: requests toggled mid-line must not take effect before a line start
    for (int ln = 0; ln < 8; ln++)
      for (int k = 0; k < 5; k++)
        pix(k == 0, (k == 0) ? ln[1] : ~ln[1] ^ k[0], (k == 0) ? ln[0] : k[1],
            CW'(ln * 9 + k), CW'(ln * 31 + k * 3 + 7), CW'(ln * 5 + k * 19 + 99));
    for (int pass = 0; pass < 256; pass++)
      pix(pass % 7 == 0, pass[3], pass[4], CW'(pass), CW'(pass ^ 8'h5a), CW'(~pass));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule